// File: doc/BRIEF.md
# Out-of-order memory request queue

This block holds memory operations waiting to go to a cache and hands them to the cache in whatever order their lines become ready, not in program order. Operations enter in program order, each with a kind, a tag and a line address. An operation is ready either on entry, when the line is already present, or later, when the cache side reports the line for that tag. Each cycle the block grants at most one ready operation to the cache. An entry stays in the queue until a completion acknowledgement with its tag comes back.

Ordinary loads and stores have no ordering among themselves. Three annotated kinds limit the reordering. A release-store waits until everything older has completed. An acquire-load holds back everything younger until it has completed. A fence does both. A fence has no cache access of its own: it leaves the queue on its own once it reaches the head. The queue is a compacting age-ordered array, so slot 0 always holds the oldest entry.

Top module: `ordq_top`

## Requirements
- R1: After reset the queue is empty, `gnt_valid` is low and `full` is low.
- R2: `in_kind` codes are: 0 load, 1 store, 2 acquire-load, 3 release-store, 4 fence. Codes 5 to 7 act as an ordinary load. `gnt_write` is high for a store or a release-store grant and low for any load.
- R3: An ordinary entry is ready when it is pushed with `in_hit` high, or when `fill_valid` arrives with its tag while it waits. It is then granted regardless of older non-ready ordinary entries. The grant appears in the cycle after the clock edge that captured the push or fill.
- R4: When several entries are eligible in one cycle, the oldest is granted, and at most one grant is made per cycle.
- R5: A release-store is not granted while any older entry remains in the queue, that is, until every older entry has been acknowledged.
- R6: Entries younger than a pending release-store are granted when ready, ahead of the release-store.
- R7: While an acquire-load is in the queue (not yet acknowledged), no younger entry is granted.
- R8: An acquire-load may be granted before older entries that are not yet ready.
- R9: A fence is never granted. It blocks every younger entry and waits for every older entry to be acknowledged. It leaves the queue one cycle after it becomes the oldest entry, and younger entries may be granted from the following cycle.
- R10: `full` is high when 8 entries are held (default depth). A push while `full` is high is dropped and leaves no entry.
- R11: Each entry is granted exactly once. An acknowledgement whose tag matches a granted entry removes it, and `full` drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Push a new operation (program order) |
| in_kind | input | 3 | Operation kind code |
| in_tag | input | TAG_W | Operation tag |
| in_addr | input | ADDR_W | Line address |
| in_hit | input | 1 | Line is already present at push |
| full | output | 1 | Queue holds DEPTH entries |
| fill_valid | input | 1 | Line became ready for `fill_tag` |
| fill_tag | input | TAG_W | Tag whose line is now ready |
| gnt_valid | output | 1 | An entry is issued to the cache this cycle |
| gnt_tag | output | TAG_W | Tag of the issued entry |
| gnt_addr | output | ADDR_W | Line address of the issued entry |
| gnt_write | output | 1 | Issued entry is a store kind |
| ack_valid | input | 1 | Completion acknowledgement |
| ack_tag | input | TAG_W | Tag of the completed entry |

## Verification
Ordinary entries are made ready out of program order, which shows that the younger entry issues first and that readiness alone controls issue. Each barrier kind gets its own pattern with a not-ready operation on one side and ready operations on the other. This tells apart blocking in the older direction and blocking in the younger direction, and it tells a grant apart from an acknowledgement. The fence pattern measures the exact cycle in which younger entries are released. A full queue receives a ready push and later a fill for that dropped tag, which shows that nothing was stored.

// File: rtl/ordq_pkg.sv
`timescale 1ns/1ps
package ordq_pkg;
   localparam int KIND_W = 3;
   localparam logic [KIND_W-1:0] K_LOAD  = 3'd0;
   localparam logic [KIND_W-1:0] K_STORE = 3'd1;
   localparam logic [KIND_W-1:0] K_ACQ   = 3'd2;
   localparam logic [KIND_W-1:0] K_REL   = 3'd3;
   localparam logic [KIND_W-1:0] K_FENCE = 3'd4;
endpackage

// File: rtl/ordq_elig.sv
`timescale 1ns/1ps
// Per-slot issue eligibility for a compacting age-ordered queue (slot 0 oldest).
module ordq_elig #(
   parameter int N = 8
) (
   input  logic [N-1:0] vld,
   input  logic [N-1:0] rdy,
   input  logic [N-1:0] gntd,
   input  logic [N-1:0] bar,   // acquire or fence: blocks younger
   input  logic [N-1:0] rel,   // release: waits for older
   input  logic [N-1:0] fen,   // never issued
   output logic [N-1:0] elig
);
   for (genvar g = 0; g < N; g++) begin : g_slot
      localparam logic [N-1:0] OLDER = (N'(1) << g) - N'(1);
      logic bar_older, occ_older;
      assign bar_older = |(bar & OLDER);
      assign occ_older = |(vld & OLDER);
      assign elig[g] = vld[g] & rdy[g] & ~gntd[g] & ~fen[g] & ~bar_older
                     & ~(rel[g] & occ_older);
   end
endmodule

// File: rtl/ordq_pick.sv
`timescale 1ns/1ps
// Lowest-index (oldest) request picker with index encoding.
module ordq_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     onehot,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   assign onehot = req & (~req + N'(1));
   assign any    = |req;
   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++)
         if (onehot[i]) idx = idx | IDX_W'(i);
   end
endmodule

// File: rtl/ordq_top.sv
`timescale 1ns/1ps
module ordq_top
   import ordq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 6,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [KIND_W-1:0] in_kind,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_hit,
   output logic              full,
   input  logic              fill_valid,
   input  logic [TAG_W-1:0]  fill_tag,
   output logic              gnt_valid,
   output logic [TAG_W-1:0]  gnt_tag,
   output logic [ADDR_W-1:0] gnt_addr,
   output logic              gnt_write,
   input  logic              ack_valid,
   input  logic [TAG_W-1:0]  ack_tag
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ordq_top: DEPTH must be at least 2");
   end
   if (TAG_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("ordq_top: TAG_W and ADDR_W must be positive");
   end

   logic [DEPTH-1:0]  vld_q, rdy_q, gntd_q, vld_d, rdy_d, gntd_d;
   logic [KIND_W-1:0] kind_q [DEPTH];
   logic [KIND_W-1:0] kind_d [DEPTH];
   logic [TAG_W-1:0]  tag_q  [DEPTH];
   logic [TAG_W-1:0]  tag_d  [DEPTH];
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [ADDR_W-1:0] addr_d [DEPTH];

   logic [DEPTH-1:0] is_bar, is_rel, is_fen, elig, pick, kill, fill_hit;
   logic [IDX_W-1:0] gnt_idx;
   logic [CNT_W-1:0] occ, ins;
   logic             push;

   // per-slot decode
   for (genvar g = 0; g < DEPTH; g++) begin : g_dec
      assign is_bar[g]   = vld_q[g] & ((kind_q[g] == K_ACQ) | (kind_q[g] == K_FENCE));
      assign is_rel[g]   = vld_q[g] & (kind_q[g] == K_REL);
      assign is_fen[g]   = vld_q[g] & (kind_q[g] == K_FENCE);
      assign fill_hit[g] = fill_valid & vld_q[g] & ~gntd_q[g] & (tag_q[g] == fill_tag);
      if (g == 0) begin : g_head
         // a fence at the head has nothing older left: it retires now
         assign kill[g] = (ack_valid & vld_q[g] & gntd_q[g] & (tag_q[g] == ack_tag))
                        | (is_fen[g] & ~ack_valid);
      end else begin : g_body
         assign kill[g] = ack_valid & vld_q[g] & gntd_q[g] & (tag_q[g] == ack_tag);
      end
   end

   ordq_elig #(.N(DEPTH)) u_elig (
      .vld (vld_q), .rdy (rdy_q), .gntd (gntd_q),
      .bar (is_bar), .rel (is_rel), .fen (is_fen), .elig (elig)
   );

   ordq_pick #(.N(DEPTH), .IDX_W(IDX_W)) u_pick (
      .req (elig), .onehot (pick), .idx (gnt_idx), .any (gnt_valid)
   );

   assign gnt_tag   = tag_q[gnt_idx];
   assign gnt_addr  = addr_q[gnt_idx];
   assign gnt_write = (kind_q[gnt_idx] == K_STORE) | (kind_q[gnt_idx] == K_REL);
   assign full      = vld_q[DEPTH-1];
   assign push      = in_valid & ~full;

   always_comb begin
      occ = '0;
      for (int i = 0; i < DEPTH; i++) occ = occ + CNT_W'(vld_q[i]);
      ins = occ - CNT_W'(|kill);
   end

   // update flags, close the gap left by a removed entry, append at the tail
   always_comb begin
      logic             sh;
      logic [DEPTH-1:0] rdy_m, gntd_m;
      rdy_m  = rdy_q | fill_hit;
      gntd_m = gntd_q | pick;
      sh     = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
         sh = sh | kill[j];
         if (!sh) begin
            vld_d[j] = vld_q[j];  rdy_d[j] = rdy_m[j];  gntd_d[j] = gntd_m[j];
            kind_d[j] = kind_q[j]; tag_d[j] = tag_q[j]; addr_d[j] = addr_q[j];
         end else if (j < DEPTH - 1) begin
            vld_d[j] = vld_q[j+1];  rdy_d[j] = rdy_m[j+1];  gntd_d[j] = gntd_m[j+1];
            kind_d[j] = kind_q[j+1]; tag_d[j] = tag_q[j+1]; addr_d[j] = addr_q[j+1];
         end else begin
            vld_d[j] = 1'b0;  rdy_d[j] = 1'b0;  gntd_d[j] = 1'b0;
            kind_d[j] = kind_q[j]; tag_d[j] = tag_q[j]; addr_d[j] = addr_q[j];
         end
         if (push && (CNT_W'(j) == ins)) begin
            vld_d[j] = 1'b1;  rdy_d[j] = in_hit;  gntd_d[j] = 1'b0;
            kind_d[j] = in_kind; tag_d[j] = in_tag; addr_d[j] = in_addr;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= '0;
         rdy_q  <= '0;
         gntd_q <= '0;
      end else begin
         vld_q  <= vld_d;
         rdy_q  <= rdy_d;
         gntd_q <= gntd_d;
      end
   end

   always_ff @(posedge clk) begin
      for (int j = 0; j < DEPTH; j++) begin
         kind_q[j] <= kind_d[j];
         tag_q[j]  <= tag_d[j];
         addr_q[j] <= addr_d[j];
      end
   end
endmodule

// File: rtl/ordq_chk.sv
`timescale 1ns/1ps
module ordq_chk #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 6,
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             gnt_valid,
   input logic [TAG_W-1:0] gnt_tag,
   input logic [IDX_W-1:0] gnt_idx,
   input logic             full,
   input logic             ack_valid,
   input logic [DEPTH-1:0] vld,
   input logic [DEPTH-1:0] rdy,
   input logic [DEPTH-1:0] gntd,
   input logic [DEPTH-1:0] bar,
   input logic [DEPTH-1:0] rel,
   input logic [DEPTH-1:0] fen
);
   logic older_bar;
   always_comb begin
      older_bar = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (IDX_W'(i) < gnt_idx && bar[i]) older_bar = 1'b1;
   end

   assert_gnt_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> (vld[gnt_idx] && rdy[gnt_idx] && !gntd[gnt_idx]));

   assert_rel_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && rel[gnt_idx]) |-> (gnt_idx == '0));

   assert_acq_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> !older_bar);

   assert_fence_never_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> !fen[gnt_idx]);

   assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !ack_valid && !fen[0]) |=> full);

   assert_single_issue_R11: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |=> !(gnt_valid && gnt_tag == $past(gnt_tag)));
endmodule

bind ordq_top ordq_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .gnt_valid (gnt_valid), .gnt_tag (gnt_tag),
   .gnt_idx (gnt_idx), .full (full), .ack_valid (ack_valid),
   .vld (vld_q), .rdy (rdy_q), .gntd (gntd_q),
   .bar (is_bar), .rel (is_rel), .fen (is_fen)
);

// File: tb/ordq_top_tb.sv
`timescale 1ns/1ps
module ordq_top_tb;
   localparam int TAG_W = 6;
   localparam int ADDR_W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_hit = 1'b0, fill_valid = 1'b0, ack_valid = 1'b0;
   logic [2:0] in_kind = '0;
   logic [TAG_W-1:0] in_tag = '0, fill_tag = '0, ack_tag = '0;
   logic [ADDR_W-1:0] in_addr = '0;
   logic full, gnt_valid, gnt_write;
   logic [TAG_W-1:0] gnt_tag;
   logic [ADDR_W-1:0] gnt_addr;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   int exp_tag[$];
   bit exp_wr[$];
   string exp_req[$];

   ordq_top #(.DEPTH(8), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_dut (
      .clk, .rst_n, .in_valid, .in_kind, .in_tag, .in_addr, .in_hit, .full,
      .fill_valid, .fill_tag, .gnt_valid, .gnt_tag, .gnt_addr, .gnt_write,
      .ack_valid, .ack_tag
   );

   always #10 clk = ~clk;

   // monitor: every grant must match the next expected item
   always @(negedge clk) begin
      if (rst_n && gnt_valid) begin
         checks++;
         if (exp_tag.size() == 0) begin
            errors++;
            $display("FAIL unexpected grant: actual tag %0d, expected none", gnt_tag);
         end else begin
            automatic int t = exp_tag.pop_front();
            automatic bit w = exp_wr.pop_front();
            automatic string r = exp_req.pop_front();
            if (gnt_tag != TAG_W'(t) || gnt_write != w) begin
               errors++;
               $display("FAIL %s grant: actual tag %0d wr %0d, expected tag %0d wr %0d",
                        r, gnt_tag, gnt_write, t, w);
            end
         end
      end
   end

   task automatic expect_g(input int t, input bit w, input string r);
      exp_tag.push_back(t); exp_wr.push_back(w); exp_req.push_back(r);
   endtask

   task automatic check(input bit ok, input string r, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d, expected %0d", r, act, exp);
      end
   endtask

   task automatic push(input logic [2:0] k, input int t, input bit hit);
      @(posedge clk); #1;
      in_valid = 1'b1; in_kind = k; in_tag = TAG_W'(t); in_hit = hit;
      in_addr = ADDR_W'(t * 64);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic fill(input int t);
      @(posedge clk); #1;
      fill_valid = 1'b1; fill_tag = TAG_W'(t);
      @(posedge clk); #1;
      fill_valid = 1'b0;
   endtask

   task automatic ack(input int t);
      @(posedge clk); #1;
      ack_valid = 1'b1; ack_tag = TAG_W'(t);
      @(posedge clk); #1;
      ack_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      settle();
      check(gnt_valid == 1'b0, "R1 grant after reset", gnt_valid, 0);
      check(full == 1'b0, "R1 full after reset", full, 0);

      // R3: younger ready store passes older waiting load; R2 kind codes
      expect_g(2, 1, "R3"); expect_g(1, 0, "R3");
      push(3'd0, 1, 0); push(3'd1, 2, 1);
      idle(2); fill(1); idle(2);
      ack(2); ack(1);
      expect_g(3, 0, "R2");
      push(3'd5, 3, 1); idle(2); ack(3);

      // R7 and R4: acquire holds younger ready entries, then oldest first
      expect_g(5, 0, "R7"); expect_g(6, 0, "R4"); expect_g(7, 1, "R4");
      push(3'd2, 5, 0); push(3'd0, 6, 1); push(3'd1, 7, 1);
      idle(3); settle();
      check(exp_tag.size() == 3, "R7 nothing before acquire ready", exp_tag.size(), 3);
      fill(5); idle(3); settle();
      check(exp_tag.size() == 2, "R7 younger held until ack", exp_tag.size(), 2);
      ack(5); idle(3); settle();
      check(exp_tag.size() == 0, "R4 both younger granted", exp_tag.size(), 0);
      ack(6); ack(7);

      // R8: acquire issues ahead of an older waiting load
      expect_g(9, 0, "R8"); expect_g(8, 0, "R8");
      push(3'd0, 8, 0); push(3'd2, 9, 1);
      idle(2); fill(8); idle(2);
      ack(9); ack(8);

      // R5 and R6: release waits for older ack; younger passes it
      expect_g(12, 0, "R6"); expect_g(10, 1, "R5"); expect_g(11, 1, "R5");
      push(3'd1, 10, 0); push(3'd3, 11, 1); push(3'd0, 12, 1);
      idle(2); fill(10); idle(3); settle();
      check(exp_tag.size() == 1, "R5 release held until older acked", exp_tag.size(), 1);
      ack(10); idle(2); settle();
      check(exp_tag.size() == 0, "R5 release granted after ack", exp_tag.size(), 0);
      ack(11); ack(12);

      // R9: fence blocks younger, retires one cycle after reaching head
      expect_g(13, 0, "R9"); expect_g(15, 0, "R9");
      push(3'd0, 13, 0); push(3'd4, 14, 0); push(3'd0, 15, 1);
      idle(3); settle();
      check(exp_tag.size() == 2, "R9 younger blocked by fence", exp_tag.size(), 2);
      fill(13); idle(3); settle();
      check(exp_tag.size() == 1, "R9 still blocked before older ack", exp_tag.size(), 1);
      ack(13);
      settle();
      check(exp_tag.size() == 1, "R9 fence at head, not yet retired", exp_tag.size(), 1);
      settle();
      check(exp_tag.size() == 0, "R9 younger granted after fence retires", exp_tag.size(), 0);
      ack(15);

      // R10 and R11: full queue, dropped push, single grant, free on ack
      for (int t = 20; t < 28; t++) push(3'd0, t, 0);
      settle();
      check(full == 1'b1, "R10 full with 8 entries", full, 1);
      push(3'd0, 28, 1);
      idle(3);
      expect_g(20, 0, "R11");
      fill(20); idle(3); settle();
      check(exp_tag.size() == 0, "R11 granted once", exp_tag.size(), 0);
      ack(20); settle();
      check(full == 1'b0, "R11 ack frees entry", full, 0);
      fill(28); idle(3); settle();
      check(gnt_valid == 1'b0, "R10 dropped push left no entry", gnt_valid, 0);
      for (int t = 21; t < 28; t++) begin
         expect_g(t, 0, "R3");
         fill(t);
      end
      idle(2);
      for (int t = 21; t < 28; t++) ack(t);
      idle(5); settle();
      check(exp_tag.size() == 0, "R3 all expected grants seen", exp_tag.size(), 0);
      check(gnt_valid == 1'b0, "R11 queue drained", gnt_valid, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule